// File: doc/BRIEF.md
# Key-Gated Capture Register Bank

This block is a bank of 32-bit registers that a host reaches through a plain valid/ready request port. A register with index n sits at byte address n*4. The bank holds two key registers, a capture control register and a read-only status word. The status word carries a fixed signature pattern. This lets software recognise a configured device. Three low bits of the status word report live state: the unlock state of the keys, the triggered flag and the capture-done flag, the last two supplied by neighbouring blocks.

Capture can only be started after a valid key pair has been written. The two key registers are compared with fixed constants after every key write. Until both match, a write that asks to start a capture has no effect. The byte-order conversion of the host link is not part of this block.

Top module: `keylock_regs`

## Requirements
- R1: After reset, the unlock flag is 0, both key registers hold 0, the run bit is 0, rsp_valid_o is 0 and cap_start_o is 0.
- R2: Register index n is selected by byte address n*4. The status register is index 2 (0x08), capture control is index 14 (0x38), key 0 is index 16 (0x40) and key 1 is index 17 (0x44). An address whose two low bits are not 00 is unmapped.
- R3: A status read returns 0xA5A5A5A0 with three bits overlaid: bit 0 is the unlock flag, bit 1 is trig_i and bit 3 is cap_done_i, as sampled in the accepting cycle.
- R4: When key 0 holds 0x641381F6 and key 1 holds 0, the unlock flag is 1 after the write that completes the pair. The status masked with 0xFFFFFFF1 then equals 0xA5A5A5A1.
- R5: The unlock flag is re-evaluated only on a key write. Rewriting a key with a matching value keeps the flag set. Rewriting a key with a mismatching value clears it.
- R6: Key registers read back the last value written to them.
- R7: A write of bit 0 = 1 to capture control while unlocked is a start. cap_start_o is high for exactly the one cycle after the accepting edge, and the run bit (bit 0 of capture control, other bits 0) reads 1.
- R8: A start write while the unlock flag is 0 is ignored: cap_start_o stays low and the run bit stays 0.
- R9: The run bit clears on a write of bit 0 = 0 to capture control, or in a cycle where cap_done_i is high and no start is accepted.
- R10: Writes to the status register and to unmapped addresses change no readable state. Reads of unmapped addresses return 0.
- R11: req_ready_o is always 1. Each accepted read gives rsp_valid_o high in the following cycle, with rsp_rdata_o valid in that cycle. Writes produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted (always 1) |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 8 | Byte address |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_rdata_o | output | 32 | Read data |
| trig_i | input | 1 | Triggered flag from the trigger unit |
| cap_done_i | input | 1 | Capture-done flag from the capture unit |
| cap_start_o | output | 1 | One-cycle capture start pulse |

## Verification
The hardest state to reach is a locked bank that was unlocked before, with a start request landing on it. To reach it, the bench first writes a full matching key pair and confirms that a start succeeds. It then corrupts one key, which relocks the bank, and sends another start write. The bench then checks that no pulse appears and that the run bit stays clear. It also sets a matching key 0 while key 1 still holds a stale mismatching value, to show that the pair is compared as a whole.

// File: rtl/keylock_regs_pkg.sv
package keylock_regs_pkg;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned STATUS_IDX = 2;
  localparam int unsigned CTRL_IDX   = 14;
  localparam int unsigned KEY0_IDX   = 16;
  localparam int unsigned KEY1_IDX   = 17;
  localparam logic [DATA_W-1:0] SIGNATURE = 32'hA5A5_A5A0;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_CTRL,
    SEL_KEY0,
    SEL_KEY1
  } reg_sel_e;
endpackage

// File: rtl/keylock_key_check.sv
module keylock_key_check
  import keylock_regs_pkg::*;
#(
  parameter logic [DATA_W-1:0] KEY0 = 32'h6413_81F6,
  parameter logic [DATA_W-1:0] KEY1 = 32'h0000_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we0_i,
  input  logic              we1_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] key0_o,
  output logic [DATA_W-1:0] key1_o,
  output logic              unlocked_o
);
  logic [DATA_W-1:0] key0_q, key1_q, key0_d, key1_d;
  logic              unlocked_q;

  assign key0_d = we0_i ? wdata_i : key0_q;
  assign key1_d = we1_i ? wdata_i : key1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key0_q     <= '0;
      key1_q     <= '0;
      unlocked_q <= 1'b0;
    end else begin
      key0_q <= key0_d;
      key1_q <= key1_d;
      // compare the pair as it stands after this write
      if (we0_i || we1_i) unlocked_q <= (key0_d == KEY0) && (key1_d == KEY1);
    end
  end

  assign key0_o     = key0_q;
  assign key1_o     = key1_q;
  assign unlocked_o = unlocked_q;

  p_unlock_on_key_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(unlocked_q) |-> $past(we0_i || we1_i));
  p_unlock_implies_match_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unlocked_q |-> (key0_q == KEY0 && key1_q == KEY1));
endmodule

// File: rtl/keylock_capture_ctl.sv
module keylock_capture_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ctrl_we_i,
  input  logic start_bit_i,
  input  logic unlocked_i,
  input  logic cap_done_i,
  output logic run_o,
  output logic cap_start_o
);
  logic start_acc, run_q, start_q;

  assign start_acc = ctrl_we_i && start_bit_i && unlocked_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= start_acc;
      if (start_acc)                            run_q <= 1'b1;
      else if (ctrl_we_i && !start_bit_i)       run_q <= 1'b0;
      else if (cap_done_i)                      run_q <= 1'b0;
    end
  end

  assign run_o       = run_q;
  assign cap_start_o = start_q;

  p_start_needs_key_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_start_o |-> $past(unlocked_i));
  p_start_sets_run_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_start_o |-> run_o);
  p_run_rises_on_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_o) |-> cap_start_o);
endmodule

// File: rtl/keylock_regs.sv
module keylock_regs
  import keylock_regs_pkg::*;
#(
  parameter int unsigned       ADDR_W = 8,
  parameter logic [DATA_W-1:0] KEY0   = 32'h6413_81F6,
  parameter logic [DATA_W-1:0] KEY1   = 32'h0000_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  input  logic              trig_i,
  input  logic              cap_done_i,
  output logic              cap_start_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]  idx;
  reg_sel_e          sel;
  logic              wr, rd;
  logic [DATA_W-1:0] key0, key1, status, rdata_d, rdata_q;
  logic              unlocked, run, rvalid_q;

  assign req_ready_o = 1'b1;
  assign idx = req_addr_i[ADDR_W-1:2];
  assign wr  = req_valid_i && req_write_i;
  assign rd  = req_valid_i && !req_write_i;

  always_comb begin
    sel = SEL_NONE;
    if (req_addr_i[1:0] == 2'b00) begin
      if (idx == IDX_W'(STATUS_IDX))    sel = SEL_STATUS;
      else if (idx == IDX_W'(CTRL_IDX)) sel = SEL_CTRL;
      else if (idx == IDX_W'(KEY0_IDX)) sel = SEL_KEY0;
      else if (idx == IDX_W'(KEY1_IDX)) sel = SEL_KEY1;
    end
  end

  keylock_key_check #(.KEY0(KEY0), .KEY1(KEY1)) u_keys (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we0_i     (wr && sel == SEL_KEY0),
    .we1_i     (wr && sel == SEL_KEY1),
    .wdata_i   (req_wdata_i),
    .key0_o    (key0),
    .key1_o    (key1),
    .unlocked_o(unlocked)
  );

  keylock_capture_ctl u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctrl_we_i  (wr && sel == SEL_CTRL),
    .start_bit_i(req_wdata_i[0]),
    .unlocked_i (unlocked),
    .cap_done_i (cap_done_i),
    .run_o      (run),
    .cap_start_o(cap_start_o)
  );

  always_comb begin
    status    = SIGNATURE;
    status[0] = unlocked;
    status[1] = trig_i;
    status[3] = cap_done_i;
  end

  always_comb begin
    unique case (sel)
      SEL_STATUS: rdata_d = status;
      SEL_CTRL:   rdata_d = {{(DATA_W-1){1'b0}}, run};
      SEL_KEY0:   rdata_d = key0;
      SEL_KEY1:   rdata_d = key1;
      default:    rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rd;
      if (rd) rdata_q <= rdata_d;
    end
  end

  assign rsp_valid_o = rvalid_q;
  assign rsp_rdata_o = rdata_q;

  p_rsp_after_read_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i) |=> rsp_valid_o);
  p_no_rsp_without_read_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && !req_write_i) |=> !rsp_valid_o);
  p_status_signature_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && sel == SEL_STATUS) |=> ((rsp_rdata_o & 32'hFFFF_FFF4) == SIGNATURE));
endmodule

// File: tb/keylock_regs_bench.sv
module keylock_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, cap_start;
  logic [31:0] rsp_rdata;
  logic        trig = 1'b0, cap_done = 1'b0;
  int          checks = 0, failures = 0;
  bit          done = 1'b0;

  localparam logic [7:0] A_STATUS = 8'h08, A_CTRL = 8'h38, A_KEY0 = 8'h40, A_KEY1 = 8'h44;
  localparam logic [31:0] GOOD_K0 = 32'h6413_81F6;

  always #4 clk = ~clk;

  keylock_regs u_keylock_regs (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .trig_i(trig), .cap_done_i(cap_done), .cap_start_o(cap_start)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, accepted at the posedge, deasserted at next negedge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check("R11 rsp_valid", {31'b0, rsp_valid}, 32'd1);
    d = rsp_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 rsp_valid", {31'b0, rsp_valid}, 32'd0);
    check("R1 cap_start", {31'b0, cap_start}, 32'd0);
    check("R11 ready", {31'b0, req_ready}, 32'd1);
    rd(A_STATUS, d); check("R1 status", d, 32'hA5A5_A5A0);
    rd(A_KEY0, d);   check("R1 key0", d, 32'd0);
    rd(A_KEY1, d);   check("R1 key1", d, 32'd0);
    rd(A_CTRL, d);   check("R1 run", d, 32'd0);
  endtask

  task automatic t_status_flags();
    logic [31:0] d;
    @(negedge clk); trig = 1'b1;
    rd(A_STATUS, d); check("R3 trig bit", d, 32'hA5A5_A5A2);
    cap_done = 1'b1;
    rd(A_STATUS, d); check("R3 done bit", d, 32'hA5A5_A5AA);
    trig = 1'b0; cap_done = 1'b0;
    rd(A_STATUS, d); check("R3 cleared", d, 32'hA5A5_A5A0);
  endtask

  task automatic t_locked_start();
    logic [31:0] d;
    wr(A_CTRL, 32'd1);
    check("R8 no pulse", {31'b0, cap_start}, 32'd0);
    rd(A_CTRL, d); check("R8 run", d, 32'd0);
  endtask

  task automatic t_unlock();
    logic [31:0] d;
    wr(A_KEY1, 32'h0000_0055);
    wr(A_KEY0, GOOD_K0);
    rd(A_STATUS, d); check("R4 pair mismatch", d, 32'hA5A5_A5A0);
    wr(A_KEY1, 32'h0);
    rd(A_STATUS, d); check("R4 unlocked", d & 32'hFFFF_FFF1, 32'hA5A5_A5A1);
    rd(A_KEY0, d); check("R6 key0", d, GOOD_K0);
    rd(A_KEY1, d); check("R6 key1", d, 32'h0);
    wr(A_KEY0, GOOD_K0);
    rd(A_STATUS, d); check("R5 match rewrite", d, 32'hA5A5_A5A1);
  endtask

  task automatic t_start_run();
    logic [31:0] d;
    wr(A_CTRL, 32'hFFFF_FFFF);
    check("R7 pulse", {31'b0, cap_start}, 32'd1);
    @(negedge clk);
    check("R7 pulse one cycle", {31'b0, cap_start}, 32'd0);
    rd(A_CTRL, d); check("R7 run", d, 32'd1);
    wr(A_CTRL, 32'd0);
    rd(A_CTRL, d); check("R9 clear by write", d, 32'd0);
    wr(A_CTRL, 32'd1);
    @(negedge clk); cap_done = 1'b1;
    @(negedge clk); cap_done = 1'b0;
    rd(A_CTRL, d); check("R9 clear by done", d, 32'd0);
  endtask

  task automatic t_ignored();
    logic [31:0] d;
    wr(A_STATUS, 32'h0);
    rd(A_STATUS, d); check("R10 status write", d, 32'hA5A5_A5A1);
    wr(8'h42, 32'h1234_5678);
    rd(A_KEY0, d); check("R10 misaligned write", d, GOOD_K0);
    rd(8'h42, d); check("R2 misaligned read", d, 32'h0);
    rd(8'h0C, d); check("R10 unmapped read", d, 32'h0);
    rd(8'h3C, d); check("R2 idx15 unmapped", d, 32'h0);
  endtask

  task automatic t_relock();
    logic [31:0] d;
    wr(A_KEY0, 32'h6413_81F7);
    rd(A_STATUS, d); check("R5 relock", d, 32'hA5A5_A5A0);
    wr(A_CTRL, 32'd1);
    check("R8 relocked no pulse", {31'b0, cap_start}, 32'd0);
    rd(A_CTRL, d); check("R8 relocked run", d, 32'd0);
    @(negedge clk); check("R11 no rsp after write", {31'b0, rsp_valid}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_status_flags();
    t_locked_start();
    t_unlock();
    t_start_run();
    t_ignored();
    t_relock();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule